// File: doc/BRIEF.md
# Windowed Bank Decoder with Control Register

This block sits between a processor and a 128 KB SRAM. It takes the processor's 16-bit address and, for each access, either selects the SRAM with a 17-bit address or answers from its own control register. The lower 64 KB of the SRAM belongs to this processor alone. The upper 64 KB holds two 32 KB banks, and each of them can be lent to this processor or to a second CPU. A 16 KB window in the processor's map shows one half of the bank that is currently lent. An external input supplies which bank that is.

The control register sets two things: whether the window sits in the top quarter of the map or in the second quarter, and which half of the shared bank the window shows. The register's top bit is a semaphore shared with the other CPU. Reading it returns the common value that comes in from outside. Writing it raises a request strobe that carries the new value. A read-data mux returns register contents, SRAM data, or all ones when no access is active.

Top module: `win_bank_dec`

## Requirements
- R1: While `cpu_req` is high, every address in 0x0200..0x020F selects the control register. A read returns bit 7 = `sem_in`, bit 6 = window position, bit 5 = half select, bit 4 = 1 and bits 3..0 = 0.
- R2: After reset is released, window position and half select are both 0.
- R3: Bits 6 and 5 of `cpu_wdata` are loaded on the clock edge only when `cpu_req` and `cpu_we` are high and the address is in the register range. Any other combination leaves them unchanged.
- R4: `sem_wr` is high in exactly the cycles in which `cpu_req` and `cpu_we` are high with the address in the register range. `sem_val` equals `cpu_wdata` bit 7.
- R5: When the position bit is 0, the window covers addresses whose bits 15..14 are 11 (0xC000..0xFFFF). When it is 1, the window covers addresses whose bits 15..14 are 01 (0x4000..0x7FFF).
- R6: On a window hit, `sram_addr` is formed as bit 16 = 1, bit 15 = `bank_sel`, bit 14 = half select, and bits 13..0 = address bits 13..0.
- R7: Any other SRAM access gives `sram_addr` = {0, `cpu_addr`}.
- R8: `cpu_rdata` is `sram_rdata` when `sram_sel` is high, register data on a register hit, and 0xFF when `cpu_req` is low.
- R9: `sram_sel` is high exactly when `cpu_req` is high and the address is outside the register range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Address and strobe are valid this cycle |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data returned to the processor |
| bank_sel | input | 1 | Which shared 32 KB bank is lent to this processor |
| sem_in | input | 1 | Common semaphore value |
| sem_wr | output | 1 | Semaphore write request |
| sem_val | output | 1 | Requested semaphore value |
| sram_sel | output | 1 | SRAM access selected |
| sram_addr | output | 17 | SRAM address |
| sram_rdata | input | 8 | Data read from the SRAM |

## Verification
The two configuration bits are the only state in the block. If either holds a wrong value, it shows up at once in two ways: as a misplaced window in `sram_addr`, and in the register's read value in the same combinational cycle. Each configuration is therefore followed by a full sweep of all 65536 addresses, for both bank selects. A register read-back checks the write qualification one clock edge after each write attempt that should be ignored, before any later write can hide a stray update.

// File: rtl/win_bank_dec.sv
module win_bank_dec #(
  parameter logic [15:0] REG_BASE = 16'h0200,
  parameter int          REG_SPAN_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  input  logic        bank_sel,
  input  logic        sem_in,
  output logic        sem_wr,
  output logic        sem_val,
  output logic        sram_sel,
  output logic [16:0] sram_addr,
  input  logic [7:0]  sram_rdata
);
  localparam int TAG_LSB = REG_SPAN_LOG2;

  logic       ctl_pos, ctl_half;
  logic       reg_hit, win_hit, reg_wr;
  logic [1:0] win_quarter;
  logic [7:0] ctl_rd;

  assign reg_hit     = cpu_req && (cpu_addr[15:TAG_LSB] == REG_BASE[15:TAG_LSB]);
  assign reg_wr      = reg_hit && cpu_we;
  assign win_quarter = ctl_pos ? 2'b01 : 2'b11;
  assign win_hit     = cpu_req && !reg_hit && (cpu_addr[15:14] == win_quarter);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_pos  <= 1'b0;
      ctl_half <= 1'b0;
    end else if (reg_wr) begin
      ctl_pos  <= cpu_wdata[6];
      ctl_half <= cpu_wdata[5];
    end

  assign sem_wr   = reg_wr;
  assign sem_val  = cpu_wdata[7];
  assign sram_sel = cpu_req && !reg_hit;
  assign sram_addr = win_hit ? {1'b1, bank_sel, ctl_half, cpu_addr[13:0]}
                             : {1'b0, cpu_addr};

  assign ctl_rd    = {sem_in, ctl_pos, ctl_half, 1'b1, 4'b0000};
  assign cpu_rdata = reg_hit  ? ctl_rd :
                     sram_sel ? sram_rdata : 8'hFF;
endmodule

// File: rtl/win_bank_dec_chk.sv
module win_bank_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [7:0]  cpu_rdata,
  input logic        sem_wr,
  input logic        sram_sel,
  input logic        ctl_pos,
  input logic        ctl_half
);
  logic in_range;
  assign in_range = (cpu_addr[15:4] == 12'h020);

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && in_range) |=> ({ctl_pos, ctl_half} == $past(cpu_wdata[6:5]))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && cpu_we && in_range) |=> $stable({ctl_pos, ctl_half})); // R3
  AST_SEM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    sem_wr |-> (cpu_req && cpu_we && in_range)); // R4
  AST_REG_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && in_range) |-> !sram_sel); // R9
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> (!sram_sel && cpu_rdata == 8'hFF)); // R8
  AST_REG_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && in_range) |-> (cpu_rdata[4:0] == 5'b10000)); // R1
endmodule

bind win_bank_dec win_bank_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .sem_wr(sem_wr), .sram_sel(sram_sel), .ctl_pos(ctl_pos), .ctl_half(ctl_half)
);

// File: tb/sim_win_bank_dec.sv
module sim_win_bank_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_wdata = 8'h0;
  logic [7:0]  cpu_rdata;
  logic        bank_sel = 1'b0, sem_in = 1'b0;
  logic        sem_wr, sem_val, sram_sel;
  logic [16:0] sram_addr;
  logic [7:0]  sram_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sram_rdata = sram_addr[7:0] ^ sram_addr[16:9];

  win_bank_dec u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d, input logic req, input logic we);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_req = req; cpu_we = we;
    #1;
    chk("R4 sem_wr", sem_wr, req && we && (a[15:4] == 12'h020));
    chk("R4 sem_val", sem_val, d[7]);
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic reg_read(input string req, input logic [15:0] a, input logic p, input logic h);
    @(negedge clk);
    cpu_addr = a; cpu_req = 1'b1; cpu_we = 1'b0;
    #1;
    chk(req, cpu_rdata, {sem_in, p, h, 1'b1, 4'b0000});
    cpu_req = 1'b0;
  endtask

  task automatic sweep(input logic p, input logic h);
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] ad;
      logic rh, wh;
      logic [16:0] ea;
      ad = a[15:0];
      cpu_addr = ad; cpu_req = 1'b1; cpu_we = 1'b0;
      #1;
      rh = (ad[15:4] == 12'h020);
      wh = !rh && (ad[15:14] == (p ? 2'b01 : 2'b11));
      ea = wh ? {1'b1, bank_sel, h, ad[13:0]} : {1'b0, ad};
      if (rh) chk("R1 R9 reg hit", {sram_sel, cpu_rdata}, {1'b0, sem_in, p, h, 1'b1, 4'b0000});
      else    chk("R5 R6 R7 R8 R9 sram", {sram_sel, sram_addr, cpu_rdata},
                  {1'b1, ea, ea[7:0] ^ ea[16:9]});
    end
    cpu_req = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    reg_read("R2 reset", 16'h0200, 1'b0, 1'b0);
    sem_in = 1'b1;
    reg_read("R1 R2 alias 0x020F", 16'h020F, 1'b0, 1'b0);
    @(negedge clk); cpu_req = 1'b0; cpu_addr = 16'h8000; #1;
    chk("R8 idle rdata", cpu_rdata, 8'hFF);
    chk("R9 idle sel", sram_sel, 1'b0);
    reg_write(16'h0205, 8'h60, 1'b0, 1'b1);
    reg_read("R3 no req", 16'h0200, 1'b0, 1'b0);
    reg_write(16'h0210, 8'h60, 1'b1, 1'b1);
    reg_read("R3 out of range", 16'h0200, 1'b0, 1'b0);
    reg_write(16'h01FF, 8'h60, 1'b1, 1'b1);
    reg_read("R3 below range", 16'h0200, 1'b0, 1'b0);
    reg_write(16'h0203, 8'h60, 1'b1, 1'b0);
    reg_read("R3 read only", 16'h0200, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 2; b++) begin
        logic p, h;
        p = c[1]; h = c[0];
        sem_in = b[0];
        bank_sel = b[0];
        reg_write(16'h0200 + 16'(c * 5), {b[0], p, h, 5'b11111}, 1'b1, 1'b1);
        reg_read("R3 load", 16'h020A, p, h);
        sweep(p, h);
      end
    end
    reg_write(16'h0200, 8'h20, 1'b1, 1'b1);
    rst_n = 1'b0; #2; rst_n = 1'b1;
    reg_read("R2 second reset", 16'h0200, 1'b0, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule